// File: doc/BRIEF.md
# Periodic Interrupt-Transfer Scheduler

This block runs the periodic part of a host-side USB schedule. It holds a small table of interrupt-transfer descriptors. Each descriptor has an armed flag, a polling exponent that sets a power-of-two period in milliseconds, and a start-frame phase. A free-running frame number advances on every 1 ms tick. At each tick the block works out which armed descriptors fall due in the new frame. It then hands them, lowest slot first and one at a time, to an external transaction engine over a valid/ready request channel.

The engine reports each outcome as a 4-bit completion code. The block stores the code in the descriptor, marks the slot in a done bitmap and disarms the descriptor, so software must re-arm it. A completion that is not a NAK raises an interrupt request toward the CPU. Only one such request can be raised per frame. The request stays high until software pulses a clear. Descriptors that the engine has not accepted by the next tick are dropped for that frame.

Top module: `periodic_poll_sched`

## Requirements
- R1: After a synchronous active-low reset: `irq` and `req_valid` are 0, `frame_num` is 0, `slot_active` and `done_map` are all zero, and every 4-bit field of `slot_codes` reads 4'hF.
- R2: `frame_num` is an 11-bit counter. It increments by one on each cycle with `frame_tick` high, holds otherwise, and wraps from 2047 to 0.
- R3: A `cfg_we` pulse writes the polling byte of slot `cfg_slot` and arms that slot. Bits [7:5] of the byte are the exponent N and bits [4:0] are the phase P. An armed slot is due in frame F when the low N bits of the 11-bit difference (F − P) are all zero. Due status is decided once, at the tick that enters frame F. Unarmed slots are never issued.
- R4: Due slots are requested in ascending slot order. `req_valid` stays high with a stable `req_slot` until `req_ready`. No new request appears until the outstanding transaction has completed.
- R5: A slot's armed bit clears on the cycle its request is accepted. The slot is not issued again until it is re-armed by `cfg_we`.
- R6: A completion (`cpl_valid` while a transaction is outstanding) writes `cpl_code` into that slot's field of `slot_codes` and sets its bit in `done_map`. A `cpl_valid` pulse with no transaction outstanding changes nothing.
- R7: A completion whose code is not NAK (4'hE) raises `irq`. This includes ACK 4'h0, STALL 4'h4 and no-response 4'h5. A NAK completion does not raise it.
- R8: `irq` rises at most once per frame. Once it has been raised and then cleared within a frame, it stays low until a later frame's completion.
- R9: `irq` stays high until an `irq_clr` pulse. That pulse also clears `done_map`.
- R10: Due slots that have not been accepted when the next tick arrives are dropped for the old frame and stay armed. They are re-evaluated against the new frame only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per 1 ms frame |
| cfg_we | input | 1 | Write polling byte and arm slot |
| cfg_slot | input | 3 | Slot written by cfg_we |
| cfg_poll | input | 8 | Polling byte: exponent [7:5], phase [4:0] |
| frame_num | output | 11 | Current frame number |
| slot_active | output | 8 | Armed flag per slot |
| slot_codes | output | 32 | Completion code per slot, slot k at bits [4k+3:4k] |
| done_map | output | 8 | Slots completed since last clear |
| req_valid | output | 1 | Transaction request to engine |
| req_slot | output | 3 | Slot being requested |
| req_ready | input | 1 | Engine accepts request |
| cpl_valid | input | 1 | Engine reports completion |
| cpl_code | input | 4 | Completion code |
| irq | output | 1 | Interrupt request to CPU |
| irq_clr | input | 1 | CPU clear pulse for irq and done_map |

## Verification
A wrong due decision shows up as an extra or missing request within a few cycles of the tick. A stale or wrongly restored pending bit shows up as a repeated or out-of-order `req_slot` in the same frame. A rate-limit flag that is lost or not re-opened by the tick shows up as a second `irq` rise inside one frame, or as a missing rise in the next one. Sweeping every exponent against its own phase for hundreds of frames, plus a counter wrap, exposes any period or phase error within one period of the affected slot.

// File: rtl/psch_pkg.sv
// Shared constants and types for the periodic interrupt-transfer scheduler.
// Assumes a 4-bit completion code as reported by the transaction engine.
package psch_pkg;
    localparam int CC_W = 4;

    localparam logic [CC_W-1:0] CC_ACK    = 4'h0;
    localparam logic [CC_W-1:0] CC_STALL  = 4'h4;
    localparam logic [CC_W-1:0] CC_NORESP = 4'h5;
    localparam logic [CC_W-1:0] CC_NAK    = 4'hE;
    localparam logic [CC_W-1:0] CC_UNUSED = 4'hF;

    typedef enum logic {
        ISS_IDLE = 1'b0,
        ISS_WAIT = 1'b1
    } iss_state_t;
endpackage

// File: rtl/psch_frame_clock.sv
// Frame number register for the scheduler.
// Advances by one on each frame_tick and wraps at 2^FRAME_W.
// Also exposes the value the counter is about to take, so that due
// decisions can be made for the frame being entered.
module psch_frame_clock #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_tick,
    output logic [FRAME_W-1:0] frame_now,
    output logic [FRAME_W-1:0] frame_next
);
    logic [FRAME_W-1:0] frame_q;

    // Next frame value, used for due evaluation at the tick
    always_comb frame_next = frame_q + FRAME_W'(1);

    // Frame counter register
    always_ff @(posedge clk) begin
        if (!rst_n)          frame_q <= '0;
        else if (frame_tick) frame_q <= frame_next;
    end

    assign frame_now = frame_q;

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> frame_q == $past(frame_q) + FRAME_W'(1)); // R2
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(frame_q)); // R2
endmodule

// File: rtl/psch_slot_table.sv
// Descriptor storage: armed flag, polling byte and completion code per slot.
// Computes, for every slot, whether it is due in the frame being entered.
// Assumes grant_slot / cpl_slot are valid whenever grant / cpl_take are high.
// A cfg write to a slot takes precedence over disarming it on the same cycle.
module psch_slot_table
    import psch_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int EXP_W     = 3,
    parameter int PHASE_W   = 5,
    parameter int FRAME_W   = 11,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int POLL_W   = EXP_W + PHASE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SLOT_W-1:0]         cfg_slot,
    input  logic [POLL_W-1:0]         cfg_poll,
    input  logic [FRAME_W-1:0]        frame_next,
    input  logic                      grant,
    input  logic [SLOT_W-1:0]         grant_slot,
    input  logic                      cpl_take,
    input  logic [SLOT_W-1:0]         cpl_slot,
    input  logic [CC_W-1:0]           cpl_code,
    output logic [NUM_SLOTS-1:0]      active_vec,
    output logic [NUM_SLOTS-1:0]      due_vec,
    output logic [NUM_SLOTS*CC_W-1:0] codes_flat
);
    logic [NUM_SLOTS-1:0] active_q;
    logic [POLL_W-1:0]    poll_q [NUM_SLOTS];
    logic [CC_W-1:0]      code_q [NUM_SLOTS];

    // Per-slot descriptor update: arm on write, disarm on grant, code on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                poll_q[i] <= '0;
                code_q[i] <= CC_UNUSED;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (cfg_we && cfg_slot == SLOT_W'(i)) begin
                    active_q[i] <= 1'b1;
                    poll_q[i]   <= cfg_poll;
                end else if (grant && grant_slot == SLOT_W'(i)) begin
                    active_q[i] <= 1'b0;
                end
                if (cpl_take && cpl_slot == SLOT_W'(i))
                    code_q[i] <= cpl_code;
            end
        end
    end

    // Due comparator per slot: low N bits of (frame - phase) must be zero
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [EXP_W-1:0]   expo;
        logic [PHASE_W-1:0] phase;
        logic [FRAME_W-1:0] delta;
        logic [FRAME_W-1:0] lowmask;

        assign expo    = poll_q[g][POLL_W-1 -: EXP_W];
        assign phase   = poll_q[g][PHASE_W-1:0];
        assign delta   = frame_next - FRAME_W'(phase);
        assign lowmask = (FRAME_W'(1) << expo) - FRAME_W'(1);
        assign due_vec[g] = active_q[g] && ((delta & lowmask) == '0);
        assign codes_flat[g*CC_W +: CC_W] = code_q[g];
    end

    assign active_vec = active_q;

    AST_ISSUE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> active_q[grant_slot]); // R3
    AST_DISARM_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !(cfg_we && cfg_slot == grant_slot)) |=> !active_q[$past(grant_slot)]); // R5
    AST_CODE_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_take |=> code_q[$past(cpl_slot)] == $past(cpl_code)); // R6
endmodule

// File: rtl/psch_issuer.sv
// Issue sequencer: holds the pending set for the current frame and hands
// slots to the transaction engine lowest-first, one outstanding at a time.
// At a tick the pending set is replaced, so unserved slots are dropped.
// A slot accepted on the tick cycle is removed from the new pending set.
module psch_issuer
    import psch_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_tick,
    input  logic [NUM_SLOTS-1:0] due_vec,
    output logic                 req_valid,
    output logic [SLOT_W-1:0]    req_slot,
    input  logic                 req_ready,
    input  logic                 cpl_valid,
    output logic                 grant,
    output logic                 cpl_take,
    output logic [SLOT_W-1:0]    cur_slot
);
    iss_state_t           state_q;
    logic [NUM_SLOTS-1:0] pending_q;
    logic [NUM_SLOTS-1:0] grant_mask;
    logic [SLOT_W-1:0]    pick_slot;
    logic [SLOT_W-1:0]    cur_q;

    // Lowest-index pending slot
    always_comb begin
        pick_slot = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--)
            if (pending_q[i]) pick_slot = SLOT_W'(i);
    end

    // Handshake and completion qualifiers
    always_comb begin
        req_valid  = (state_q == ISS_IDLE) && (pending_q != '0);
        req_slot   = pick_slot;
        grant      = req_valid && req_ready;
        grant_mask = grant ? (NUM_SLOTS'(1) << pick_slot) : '0;
        cpl_take   = (state_q == ISS_WAIT) && cpl_valid;
    end

    // Pending set: reload at tick, shrink on each grant
    always_ff @(posedge clk) begin
        if (!rst_n)          pending_q <= '0;
        else if (frame_tick) pending_q <= due_vec & ~grant_mask;
        else                 pending_q <= pending_q & ~grant_mask;
    end

    // Outstanding-transaction state and its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ISS_IDLE;
            cur_q   <= '0;
        end else begin
            case (state_q)
                ISS_IDLE: if (grant) begin
                    state_q <= ISS_WAIT;
                    cur_q   <= pick_slot;
                end
                ISS_WAIT: if (cpl_valid) state_q <= ISS_IDLE;
                default:  state_q <= ISS_IDLE;
            endcase
        end
    end

    assign cur_slot = cur_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !frame_tick) |=> (req_valid && $stable(req_slot))); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !req_valid); // R4
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_take && !frame_tick && $past(!frame_tick)) |=> (!req_valid || req_slot > cur_q)); // R4
endmodule

// File: rtl/psch_irq_gate.sv
// Interrupt gate and done bitmap.
// Raises irq on a non-NAK completion, at most once per frame; the tick
// reopens the gate. irq_clr drops irq and clears the done bitmap; a
// completion on the same cycle wins over the clear.
module psch_irq_gate
    import psch_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_tick,
    input  logic                 cpl_take,
    input  logic [SLOT_W-1:0]    cpl_slot,
    input  logic [CC_W-1:0]      cpl_code,
    input  logic                 irq_clr,
    output logic                 irq,
    output logic [NUM_SLOTS-1:0] done_map
);
    logic                 irq_q;
    logic                 fired_q;
    logic                 fired_open;
    logic                 fire;
    logic [NUM_SLOTS-1:0] done_q;

    // Gate is reopened by the tick; fire on the first worthy outcome
    always_comb begin
        fired_open = frame_tick ? 1'b0 : fired_q;
        fire       = cpl_take && (cpl_code != CC_NAK) && !fired_open;
    end

    // Interrupt request and per-frame fired flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            fired_q <= fired_open | fire;
            if (fire)         irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    // Done bitmap: cleared by CPU, set by completions
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= '0;
        else        done_q <= (irq_clr ? '0 : done_q) |
                              (cpl_take ? (NUM_SLOTS'(1) << cpl_slot) : '0);
    end

    assign irq      = irq_q;
    assign done_map = done_q;

    AST_IRQ_ONCE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_q && !frame_tick) |=> !$rose(irq_q)); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(cpl_take && cpl_code != CC_NAK)); // R7
    AST_NAK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_take && cpl_code == CC_NAK && !irq_q) |=> !irq_q); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q); // R9
endmodule

// File: rtl/periodic_poll_sched.sv
// Periodic interrupt-transfer scheduler, top level.
// Connects the frame clock, descriptor table, issue sequencer and
// interrupt gate. Assumes frame_tick is a one-cycle pulse and that the
// engine returns exactly one completion per accepted request.
module periodic_poll_sched
    import psch_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int EXP_W     = 3,
    parameter int PHASE_W   = 5,
    parameter int FRAME_W   = 11,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int POLL_W   = EXP_W + PHASE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_tick,
    input  logic                      cfg_we,
    input  logic [SLOT_W-1:0]         cfg_slot,
    input  logic [POLL_W-1:0]         cfg_poll,
    output logic [FRAME_W-1:0]        frame_num,
    output logic [NUM_SLOTS-1:0]      slot_active,
    output logic [NUM_SLOTS*CC_W-1:0] slot_codes,
    output logic [NUM_SLOTS-1:0]      done_map,
    output logic                      req_valid,
    output logic [SLOT_W-1:0]         req_slot,
    input  logic                      req_ready,
    input  logic                      cpl_valid,
    input  logic [CC_W-1:0]           cpl_code,
    output logic                      irq,
    input  logic                      irq_clr
);
    logic [FRAME_W-1:0]   frame_next;
    logic [NUM_SLOTS-1:0] due_vec;
    logic                 grant;
    logic                 cpl_take;
    logic [SLOT_W-1:0]    cur_slot;

    psch_frame_clock #(.FRAME_W(FRAME_W)) u_clock (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .frame_now  (frame_num),
        .frame_next (frame_next)
    );

    psch_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .EXP_W     (EXP_W),
        .PHASE_W   (PHASE_W),
        .FRAME_W   (FRAME_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_slot   (cfg_slot),
        .cfg_poll   (cfg_poll),
        .frame_next (frame_next),
        .grant      (grant),
        .grant_slot (req_slot),
        .cpl_take   (cpl_take),
        .cpl_slot   (cur_slot),
        .cpl_code   (cpl_code),
        .active_vec (slot_active),
        .due_vec    (due_vec),
        .codes_flat (slot_codes)
    );

    psch_issuer #(.NUM_SLOTS(NUM_SLOTS)) u_issuer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .due_vec    (due_vec),
        .req_valid  (req_valid),
        .req_slot   (req_slot),
        .req_ready  (req_ready),
        .cpl_valid  (cpl_valid),
        .grant      (grant),
        .cpl_take   (cpl_take),
        .cur_slot   (cur_slot)
    );

    psch_irq_gate #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .cpl_take   (cpl_take),
        .cpl_slot   (cur_slot),
        .cpl_code   (cpl_code),
        .irq_clr    (irq_clr),
        .irq        (irq),
        .done_map   (done_map)
    );

    AST_NO_STRAY_REQ_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !req_valid && !irq); // R1
endmodule

// File: tb/test_periodic_poll_sched.sv
// Self-checking bench: sweeps every polling exponent against its own phase
// over hundreds of frames, then covers wrap, drop, rate limit and stray
// completions. Inputs are driven at the falling edge.
module test_periodic_poll_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_slot = '0;
    logic [7:0]  cfg_poll = '0;
    logic [10:0] frame_num;
    logic [7:0]  slot_active;
    logic [31:0] slot_codes;
    logic [7:0]  done_map;
    logic        req_valid;
    logic [2:0]  req_slot;
    logic        req_ready = 1'b0;
    logic        cpl_valid = 1'b0;
    logic [3:0]  cpl_code = '0;
    logic        irq;
    logic        irq_clr = 1'b0;

    int errors = 0;
    int checks = 0;

    // engine model state and frame logs
    int         eng_st = 0;
    bit         eng_en = 1'b1;
    bit         force_ack = 1'b0;
    bit         clr_on_irq = 1'b0;
    int         code_ctr = 0;
    logic [2:0] eng_slot = '0;
    logic [7:0] issued = '0;
    bit         order_ok = 1'b1;
    int         last_slot = -1;
    logic [3:0] exp_code [8];
    bit         worthy = 1'b0;
    int         irq_rises = 0;
    bit         irq_prev = 1'b0;

    always #10 clk = ~clk;

    periodic_poll_sched i_periodic_poll_sched (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_poll(cfg_poll),
        .frame_num(frame_num), .slot_active(slot_active),
        .slot_codes(slot_codes), .done_map(done_map),
        .req_valid(req_valid), .req_slot(req_slot), .req_ready(req_ready),
        .cpl_valid(cpl_valid), .cpl_code(cpl_code),
        .irq(irq), .irq_clr(irq_clr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pick_code(input int n);
        case (n % 4)
            0: return 4'h0;
            1: return 4'hE;
            2: return 4'h4;
            default: return 4'h5;
        endcase
    endfunction

    // One cycle: sample at the falling edge, clear pulses, run the engine model
    task automatic step();
        @(negedge clk);
        if (irq && !irq_prev) irq_rises++;
        irq_prev   = irq;
        frame_tick = 1'b0;
        cfg_we     = 1'b0;
        irq_clr    = 1'b0;
        case (eng_st)
            0: begin
                cpl_valid = 1'b0;
                if (eng_en && req_valid) begin
                    req_ready = 1'b1;
                    eng_slot  = req_slot;
                    if (int'(req_slot) <= last_slot) order_ok = 1'b0;
                    last_slot = int'(req_slot);
                    issued[req_slot] = 1'b1;
                    eng_st = 1;
                end
            end
            1: begin req_ready = 1'b0; eng_st = 2; end
            2: begin
                cpl_valid = 1'b1;
                cpl_code  = force_ack ? 4'h0 : pick_code(code_ctr);
                code_ctr++;
                exp_code[eng_slot] = cpl_code;
                if (cpl_code != 4'hE) worthy = 1'b1;
                eng_st = 3;
            end
            default: begin cpl_valid = 1'b0; eng_st = 0; end
        endcase
        if (clr_on_irq && irq) irq_clr = 1'b1;
    endtask

    task automatic arm(input int slot, input int n, input int ph);
        step();
        cfg_we   = 1'b1;
        cfg_slot = 3'(slot);
        cfg_poll = {3'(n), 5'(ph)};
    endtask

    task automatic clear_logs();
        issued = '0; order_ok = 1'b1; last_slot = -1;
        worthy = 1'b0; irq_rises = 0;
    endtask

    task automatic do_tick();
        step();
        clear_logs();
        frame_tick = 1'b1;
    endtask

    task automatic drain();
        int quiet = 0;
        int guard = 0;
        while (quiet < 3 && guard < 400) begin
            step();
            if (!req_valid && eng_st == 0 && !cpl_valid) quiet++;
            else quiet = 0;
            guard++;
        end
    endtask

    function automatic logic [7:0] expect_due(input logic [7:0] armed,
                                              input logic [10:0] f,
                                              input int ns [8], input int ps [8]);
        logic [7:0] m = '0;
        for (int i = 0; i < 8; i++) begin
            logic [10:0] d  = f - 11'(ps[i]);
            logic [10:0] lm = (11'd1 << ns[i]) - 11'd1;
            m[i] = armed[i] && ((d & lm) == '0);
        end
        return m;
    endfunction

    // Checks after a drained frame, then CPU clear
    task automatic eval_frame(input logic [7:0] exp_mask, input string tag);
        chk(issued == exp_mask, "R3", {tag, " issued set"}, issued, exp_mask);
        chk(order_ok, "R4", {tag, " ascending order"}, order_ok, 1);
        chk((slot_active & issued) == '0, "R5", {tag, " disarm"}, slot_active & issued, 0);
        chk(done_map == issued, "R6", {tag, " done_map"}, done_map, issued);
        for (int i = 0; i < 8; i++)
            if (issued[i])
                chk(slot_codes[i*4 +: 4] == exp_code[i], "R6", {tag, " code"},
                    slot_codes[i*4 +: 4], exp_code[i]);
        chk(irq == worthy, "R7", {tag, " irq level"}, irq, worthy);
        chk(irq_rises <= 1, "R8", {tag, " irq rises"}, irq_rises, 1);
        step();
        irq_clr = 1'b1;
        step();
        chk(irq == 1'b0 && done_map == '0, "R9", {tag, " clear"}, {irq, done_map}, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int ns [8];
        int ps [8];
        logic [7:0]  armed;
        logic [7:0]  em;
        logic [31:0] saved;

        for (int i = 0; i < 8; i++) exp_code[i] = 4'hF;
        repeat (3) step();
        chk(irq == 0 && req_valid == 0, "R1", "reset irq/req", {irq, req_valid}, 0);
        chk(frame_num == 0 && slot_active == 0 && done_map == 0, "R1", "reset state",
            {frame_num, slot_active, done_map}, 0);
        chk(slot_codes == 32'hFFFF_FFFF, "R1", "reset codes", slot_codes, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        step();

        // Sweep: slot i uses exponent i and its own phase, re-armed every frame
        for (int i = 0; i < 8; i++) begin ns[i] = i; ps[i] = (5 * i + 3) % 32; end
        for (int fr = 0; fr < 300; fr++) begin
            for (int i = 0; i < 8; i++) arm(i, ns[i], ps[i]);
            step();
            armed = slot_active;
            do_tick();
            step();
            chk(frame_num == 11'(fr + 1), "R2", "frame count", frame_num, fr + 1);
            drain();
            em = expect_due(armed, frame_num, ns, ps);
            eval_frame(em, "sweep");
        end

        // Stray completion with nothing outstanding
        saved = slot_codes;
        step();
        cpl_valid = 1'b1;
        cpl_code  = 4'h5;
        step();
        step();
        chk(done_map == 0 && irq == 0, "R6", "stray cpl ignored", {irq, done_map}, 0);
        chk(slot_codes == saved, "R6", "stray cpl codes", slot_codes, saved);

        // Fast ticks to the wrap point
        drain();
        while (frame_num != 11'd2047) begin
            step();
            frame_tick = 1'b1;
            drain();
        end
        step();
        irq_clr = 1'b1;
        drain();
        for (int i = 0; i < 8; i++) begin ns[i] = 3; ps[i] = 0; end
        arm(0, 3, 0);
        arm(6, 3, 1);
        step();
        armed = slot_active;
        do_tick();
        step();
        chk(frame_num == 0, "R2", "wrap to zero", frame_num, 0);
        ps[6] = 1;
        drain();
        em = expect_due(armed, frame_num, ns, ps);
        chk(em[0] == 1'b1, "R2", "wrap due calc", em[0], 1);
        eval_frame(em, "wrap");

        // Rate limit: three ACKs, CPU clears after the first
        drain();
        for (int i = 0; i < 8; i++) begin
            if (slot_active[i]) begin
                step(); cfg_we = 1'b1; cfg_slot = 3'(i); cfg_poll = 8'h1F;
            end
        end
        drain();
        do_tick(); drain();
        step(); irq_clr = 1'b1; step();
        force_ack = 1'b1;
        clr_on_irq = 1'b1;
        arm(0, 0, 0); arm(1, 0, 0); arm(2, 0, 0);
        do_tick();
        drain();
        chk(issued == 8'h07, "R4", "three issued", issued, 8'h07);
        chk(irq_rises == 1, "R8", "one rise after clear", irq_rises, 1);
        chk(irq == 0, "R8", "no re-raise in frame", irq, 0);
        clr_on_irq = 1'b0;
        step();
        arm(4, 0, 0);
        do_tick();
        drain();
        chk(irq == 1 && irq_rises == 1, "R7", "ACK raises next frame", {irq, 8'(irq_rises)}, 9'h101);
        chk(irq == 1, "R9", "irq held until clear", irq, 1);
        step(); irq_clr = 1'b1; step();
        force_ack = 1'b0;

        // Drop: engine stalled across a tick
        eng_en = 1'b0;
        step();
        em = 8'(frame_num + 11'd1);
        arm(3, 0, 0);
        arm(5, 1, int'(em[0]));
        do_tick();
        repeat (4) step();
        chk(req_valid && req_slot == 3, "R4", "request held", {req_valid, req_slot}, {1'b1, 3'd3});
        do_tick();
        step();
        eng_en = 1'b1;
        drain();
        chk(issued == 8'h08, "R10", "unserved slot dropped", issued, 8'h08);
        chk(slot_active[5] == 1'b1, "R10", "dropped slot stays armed", slot_active[5], 1);
        chk(slot_active[3] == 1'b0, "R5", "issued slot disarmed", slot_active[3], 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule